// File: doc/BRIEF.md
# Nested Lock Renaming Bookkeeper

This block does the bookkeeping in front of a hardware race detector. Each core's debug agent sends it one packet per thread event. A packet is a thread creation, a thread exit, a successful lock acquisition or a lock release, and it carries a core number, a thread number and the address of the lock. The block keeps a per-core status table that records the owning thread, whether the core holds a lock group, and which group that is. It also keeps a small pool of lock groups. Each group holds a 16-bit nesting bitmap that fills from bit 0 upward.

The block renames every acquisition to a compact key (group, level) and does not store each lock address separately. The first lock a core takes claims a free group at level 0. Each nested lock moves one level deeper in the same group, and each release gives back the deepest level. The last release, or a thread exit, returns the group to the pool. Every packet also gets a per-core sequence number, which restarts when the thread exits. One cycle after each packet, the result appears as a registered key, sequence number, owner thread and address, together with two error flags.

Top module: `lock_rename_bookkeeper`

## Requirements
- R1: After reset, out_valid, err_overflow and err_depth are 0, every lock group is free, and every core's sequence count and owner thread are 0.
- R2: Each cycle with ev_valid high produces exactly one cycle of out_valid high on the following cycle. A cycle with ev_valid low produces out_valid low on the next cycle. out_addr echoes the packet's address.
- R3: A lock packet (ev_op = 2) from a core that holds no group claims the lowest-numbered free group and reports the key (that group, 0).
- R4: A lock packet from a core that already holds a group with n levels in use (1 <= n <= 15) reports the key (same group, n) and makes n+1 levels in use.
- R5: An unlock packet (ev_op = 3) from a core holding a group with n levels reports the key (group, n-1) and leaves n-1 levels. When n was 1, the group returns to the free pool and the core holds no group.
- R6: A lock packet from a core holding no group while no group is free raises err_overflow for one cycle. It reports the key (0, 0) and changes no table.
- R7: A lock packet from a core whose group already has all 16 levels raises err_depth for one cycle. It reports (group, 15) and leaves the bitmap unchanged, so a following unlock still reports level 15.
- R8: out_seq carries the core's count of packets since reset or since its last exit, taken before this packet is counted. An exit packet (ev_op = 1) reports its count and then restarts the core's count at 0.
- R9: An exit packet releases any group the core held. The group becomes free for the next claim. The exit reports the key (held group, 0), or (0, 0) if the core held none.
- R10: An unlock packet from a core holding no group reports the key (0, 0), raises no error and changes no table.
- R11: A create packet (ev_op = 0) records ev_tid as the core's owner thread and reports it on out_tid. Every other packet reports the owner recorded for that core, which is 0 after reset or exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Packet present this cycle |
| ev_op | input | 2 | 0 create, 1 exit, 2 lock, 3 unlock |
| ev_core | input | CORE_W | Issuing core number |
| ev_tid | input | TID_W | Thread number carried by the packet |
| ev_addr | input | ADDR_W | Lock address carried by the packet |
| out_valid | output | 1 | Result present |
| out_set | output | SET_W | Renamed key: group index |
| out_level | output | LVL_W | Renamed key: nesting level |
| out_seq | output | SEQ_W | Per-core sequence number |
| out_tid | output | TID_W | Owner thread of the core |
| out_addr | output | ADDR_W | Echoed lock address |
| err_overflow | output | 1 | No free group for a new claim |
| err_depth | output | 1 | Nesting deeper than 16 levels refused |

## Verification
Every result and both error flags come from a single output register, so each one is due exactly one clock edge after the packet that caused it. The bench drives a packet on a falling edge. It then waits one rising edge and checks all outputs on the next falling edge against a behavioural model, which updates its integer tables in the same step. Idle cycles are checked the same way, and each must show out_valid low. Effects that span several packets are checked through later keys. A freed group is seen through the index the next claim receives, and a refused deep lock through the level the next unlock reports.

// File: rtl/lrb_pkg.sv
package lrb_pkg;
   typedef enum logic [1:0] {
      OP_CREATE = 2'd0,
      OP_EXIT   = 2'd1,
      OP_LOCK   = 2'd2,
      OP_UNLOCK = 2'd3
   } lrb_op_e;
endpackage

// File: rtl/lrb_free_pick.sv
module lrb_free_pick #(
   parameter int NUM_SETS     = 8,
   parameter bit LOWEST_FIRST = 1'b1,
   localparam int SET_W       = $clog2(NUM_SETS)
) (
   input  logic [NUM_SETS-1:0] free_mask,
   output logic                any_free,
   output logic [SET_W-1:0]    pick_idx
);
   assign any_free = |free_mask;

   generate
      if (LOWEST_FIRST) begin : g_low
         always_comb begin
            pick_idx = '0;
            for (int i = NUM_SETS - 1; i >= 0; i--)
               if (free_mask[i]) pick_idx = SET_W'(i);
         end
      end else begin : g_high
         always_comb begin
            pick_idx = '0;
            for (int i = 0; i < NUM_SETS; i++)
               if (free_mask[i]) pick_idx = SET_W'(i);
         end
      end
   endgenerate
endmodule

// File: rtl/lrb_level_calc.sv
module lrb_level_calc #(
   parameter int LEVELS = 16,
   localparam int LVL_W = $clog2(LEVELS)
) (
   input  logic [LEVELS-1:0] level_map,
   output logic              full,
   output logic [LVL_W-1:0]  next_lvl,
   output logic [LVL_W-1:0]  top_lvl
);
   logic [LVL_W:0] in_use;

   always_comb begin
      in_use = '0;
      for (int i = 0; i < LEVELS; i++)
         in_use = in_use + (LVL_W + 1)'(level_map[i]);
   end

   assign full     = in_use[LVL_W];
   assign next_lvl = in_use[LVL_W-1:0];
   assign top_lvl  = in_use[LVL_W-1:0] - 1'b1;
endmodule

// File: rtl/lock_rename_bookkeeper.sv
module lock_rename_bookkeeper
   import lrb_pkg::*;
#(
   parameter int NUM_CORES    = 8,
   parameter int NUM_SETS     = 8,
   parameter int LEVELS       = 16,
   parameter int TID_W        = 8,
   parameter int ADDR_W       = 32,
   parameter int SEQ_W        = 16,
   parameter bit LOWEST_FIRST = 1'b1,
   localparam int CORE_W      = $clog2(NUM_CORES),
   localparam int SET_W       = $clog2(NUM_SETS),
   localparam int LVL_W       = $clog2(LEVELS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_valid,
   input  logic [1:0]        ev_op,
   input  logic [CORE_W-1:0] ev_core,
   input  logic [TID_W-1:0]  ev_tid,
   input  logic [ADDR_W-1:0] ev_addr,
   output logic              out_valid,
   output logic [SET_W-1:0]  out_set,
   output logic [LVL_W-1:0]  out_level,
   output logic [SEQ_W-1:0]  out_seq,
   output logic [TID_W-1:0]  out_tid,
   output logic [ADDR_W-1:0] out_addr,
   output logic              err_overflow,
   output logic              err_depth
);
   generate
      if (NUM_CORES < 2 || NUM_SETS < 2) begin : g_bad_size
         $error("lock_rename_bookkeeper: NUM_CORES and NUM_SETS must be at least 2");
      end
      if (LEVELS < 2 || (1 << LVL_W) != LEVELS) begin : g_bad_levels
         $error("lock_rename_bookkeeper: LEVELS must be a power of two >= 2");
      end
   endgenerate

   // core-status table
   logic [TID_W-1:0]  cs_tid  [NUM_CORES];
   logic              cs_held [NUM_CORES];
   logic [SET_W-1:0]  cs_set  [NUM_CORES];
   logic [SEQ_W-1:0]  cs_seq  [NUM_CORES];
   // lock-group table
   logic [LEVELS-1:0] ls_map  [NUM_SETS];
   logic [NUM_SETS-1:0] free_mask;

   lrb_op_e           op;
   logic              held;
   logic [SET_W-1:0]  cur_set;
   logic [LEVELS-1:0] cur_map;
   logic              map_full;
   logic [LVL_W-1:0]  next_lvl, top_lvl;
   logic              any_free;
   logic [SET_W-1:0]  alloc_idx;

   assign op      = lrb_op_e'(ev_op);
   assign held    = cs_held[ev_core];
   assign cur_set = cs_set[ev_core];
   assign cur_map = ls_map[cur_set];

   lrb_level_calc #(.LEVELS(LEVELS)) u_level (
      .level_map (cur_map),
      .full      (map_full),
      .next_lvl  (next_lvl),
      .top_lvl   (top_lvl)
   );

   lrb_free_pick #(.NUM_SETS(NUM_SETS), .LOWEST_FIRST(LOWEST_FIRST)) u_pick (
      .free_mask (free_mask),
      .any_free  (any_free),
      .pick_idx  (alloc_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < NUM_CORES; c++) begin
            cs_tid[c]  <= '0;
            cs_held[c] <= 1'b0;
            cs_set[c]  <= '0;
            cs_seq[c]  <= '0;
         end
         for (int s = 0; s < NUM_SETS; s++) ls_map[s] <= '0;
         free_mask    <= '1;
         out_valid    <= 1'b0;
         out_set      <= '0;
         out_level    <= '0;
         out_seq      <= '0;
         out_tid      <= '0;
         out_addr     <= '0;
         err_overflow <= 1'b0;
         err_depth    <= 1'b0;
      end else begin
         out_valid    <= ev_valid;
         err_overflow <= 1'b0;
         err_depth    <= 1'b0;
         if (ev_valid) begin
            out_seq   <= cs_seq[ev_core];
            out_tid   <= cs_tid[ev_core];
            out_addr  <= ev_addr;
            out_set   <= '0;
            out_level <= '0;
            cs_seq[ev_core] <= cs_seq[ev_core] + 1'b1;
            case (op)
               OP_CREATE: begin
                  cs_tid[ev_core] <= ev_tid;
                  out_tid         <= ev_tid;
               end
               OP_EXIT: begin
                  cs_seq[ev_core]  <= '0;
                  cs_tid[ev_core]  <= '0;
                  cs_held[ev_core] <= 1'b0;
                  if (held) begin
                     free_mask[cur_set] <= 1'b1;
                     ls_map[cur_set]    <= '0;
                     out_set            <= cur_set;
                  end
               end
               OP_LOCK: begin
                  if (held) begin
                     out_set <= cur_set;
                     if (map_full) begin
                        err_depth <= 1'b1;
                        out_level <= LVL_W'(LEVELS - 1);
                     end else begin
                        ls_map[cur_set] <= {cur_map[LEVELS-2:0], 1'b1};
                        out_level       <= next_lvl;
                     end
                  end else if (any_free) begin
                     free_mask[alloc_idx] <= 1'b0;
                     ls_map[alloc_idx]    <= LEVELS'(1);
                     cs_held[ev_core]     <= 1'b1;
                     cs_set[ev_core]      <= alloc_idx;
                     out_set              <= alloc_idx;
                  end else begin
                     err_overflow <= 1'b1;
                  end
               end
               default: begin
                  if (held) begin
                     out_set         <= cur_set;
                     out_level       <= top_lvl;
                     ls_map[cur_set] <= cur_map >> 1;
                     if (top_lvl == '0) begin
                        free_mask[cur_set] <= 1'b1;
                        cs_held[ev_core]   <= 1'b0;
                     end
                  end
               end
            endcase
         end
      end
   end

   // a fresh claim takes a free group and starts at level 0
   assert_alloc_claims_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && op == OP_LOCK && !held && any_free)
      |=> (!free_mask[$past(alloc_idx)] && out_level == '0 && out_set == $past(alloc_idx)));

   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      err_overflow |-> ($past(free_mask) == '0));

   assert_depth_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err_depth |-> (out_level == LVL_W'(LEVELS - 1) && !err_overflow));

   assert_out_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(ev_valid));

   assert_exit_frees_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && op == OP_EXIT && held) |=> free_mask[$past(cur_set)]);

   assert_unlock_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && op == OP_UNLOCK && !held) |=> ($stable(free_mask) && out_level == '0));
endmodule

// File: tb/lock_rename_bookkeeper_test.sv
`timescale 1ns/1ps
module lock_rename_bookkeeper_test;
   localparam int NC = 8, NS = 4, LV = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_valid = 1'b0;
   logic [1:0]  ev_op = '0;
   logic [2:0]  ev_core = '0;
   logic [7:0]  ev_tid = '0;
   logic [31:0] ev_addr = '0;
   logic        out_valid, err_overflow, err_depth;
   logic [1:0]  out_set;
   logic [3:0]  out_level;
   logic [15:0] out_seq;
   logic [7:0]  out_tid;
   logic [31:0] out_addr;

   int checks = 0, errors = 0;
   int m_held [NC], m_seq [NC], m_tid [NC];
   int m_depth [NS];
   bit m_free [NS];

   always #4 clk = ~clk;

   lock_rename_bookkeeper #(.NUM_CORES(NC), .NUM_SETS(NS), .LEVELS(LV)) uut (
      .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_op(ev_op), .ev_core(ev_core),
      .ev_tid(ev_tid), .ev_addr(ev_addr), .out_valid(out_valid), .out_set(out_set),
      .out_level(out_level), .out_seq(out_seq), .out_tid(out_tid), .out_addr(out_addr),
      .err_overflow(err_overflow), .err_depth(err_depth));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic idle();
      ev_valid = 1'b0;
      @(posedge clk); @(negedge clk);
      chk(out_valid == 1'b0, "R2 idle valid", out_valid, 0);
   endtask

   task automatic step(input int op, input int core, input int tid, input int addr);
      int e_set = 0, e_lvl = 0, e_seq, e_tid, e_ov = 0, e_dp = 0;
      string tag;
      e_seq = m_seq[core];
      e_tid = m_tid[core];
      m_seq[core] = (m_seq[core] + 1) % 65536;
      case (op)
         0: begin tag = "R11"; m_tid[core] = tid; e_tid = tid; end
         1: begin
            tag = "R9";
            if (m_held[core] >= 0) begin
               e_set = m_held[core]; m_free[e_set] = 1; m_depth[e_set] = 0;
            end
            m_held[core] = -1; m_seq[core] = 0; m_tid[core] = 0;
         end
         2: begin
            if (m_held[core] >= 0) begin
               e_set = m_held[core];
               if (m_depth[e_set] == LV) begin tag = "R7"; e_dp = 1; e_lvl = LV - 1; end
               else begin tag = "R4"; e_lvl = m_depth[e_set]; m_depth[e_set]++; end
            end else begin
               int f = -1;
               for (int s = NS - 1; s >= 0; s--) if (m_free[s]) f = s;
               if (f < 0) begin tag = "R6"; e_ov = 1; end
               else begin
                  tag = "R3"; e_set = f; m_free[f] = 0; m_depth[f] = 1; m_held[core] = f;
               end
            end
         end
         default: begin
            if (m_held[core] >= 0) begin
               tag = "R5"; e_set = m_held[core];
               m_depth[e_set]--; e_lvl = m_depth[e_set];
               if (m_depth[e_set] == 0) begin m_free[e_set] = 1; m_held[core] = -1; end
            end else tag = "R10";
         end
      endcase
      ev_valid = 1'b1; ev_op = 2'(op); ev_core = 3'(core); ev_tid = 8'(tid); ev_addr = 32'(addr);
      @(posedge clk); @(negedge clk);
      ev_valid = 1'b0;
      chk(out_valid == 1'b1, "R2 valid", out_valid, 1);
      chk(out_addr == 32'(addr), "R2 addr", out_addr, addr);
      chk(out_set == 2'(e_set), {tag, " set"}, out_set, e_set);
      chk(out_level == 4'(e_lvl), {tag, " level"}, out_level, e_lvl);
      chk(err_overflow == e_ov, {tag, " R6 overflow flag"}, err_overflow, e_ov);
      chk(err_depth == e_dp, {tag, " R7 depth flag"}, err_depth, e_dp);
      chk(out_seq == 16'(e_seq), "R8 seq", out_seq, e_seq);
      chk(out_tid == 8'(e_tid), "R11 tid", out_tid, e_tid);
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int c = 0; c < NC; c++) begin m_held[c] = -1; m_seq[c] = 0; m_tid[c] = 0; end
      for (int s = 0; s < NS; s++) begin m_free[s] = 1; m_depth[s] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state at the ports
      chk(out_valid == 0, "R1 valid", out_valid, 0);
      chk(err_overflow == 0 && err_depth == 0, "R1 errors", err_overflow + err_depth, 0);
      idle();
      for (int c = 0; c < 7; c++) step(0, c, 16 + c, 0);
      step(2, 0, 0, 32'h100); step(2, 0, 0, 32'h104); step(2, 0, 0, 32'h108);  // R3 R4
      step(3, 0, 0, 32'h108);                                                    // R5
      step(2, 1, 0, 32'h200); step(2, 2, 0, 32'h300); step(2, 3, 0, 32'h400);
      idle();
      step(2, 4, 0, 32'h500);                                                    // R6
      step(3, 0, 0, 32'h104); step(3, 0, 0, 32'h100);                            // R5 free
      step(2, 4, 0, 32'h500);                                                    // R3 reuse
      step(3, 1, 0, 32'h200);
      for (int k = 0; k < LV; k++) step(2, 5, 0, 32'h600 + k * 4);               // R4
      step(2, 5, 0, 32'h700);                                                    // R7
      step(3, 5, 0, 32'h63c);                                                    // R7 unchanged
      step(3, 6, 0, 32'h800);                                                    // R10
      step(1, 2, 0, 0);                                                          // R9 R8
      step(2, 6, 0, 32'h900);                                                    // R9 reuse
      step(0, 2, 77, 0); step(2, 2, 0, 32'ha00);                                 // R8 R11
      step(1, 7, 0, 0);                                                          // R9 none
      for (int k = 0; k < 40; k++) step((k * 7 + 3) % 4, (k * 5) % NC, k, k * 16);
      idle();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule